// File: doc/BRIEF.md
# Outstanding-Event Dead-Time Controller

This block keeps a central count of triggered events that still sit in a front-end buffer of fixed depth. It raises a busy (dead-time) output one slot before that buffer is full. An event that is already on its way when busy rises therefore still finds a free slot. Every accepted trigger adds one to the count. Every completion token that comes back from the receiver side removes one.

The completion token is a one-cycle pulse that travels serially through a chain of receiver nodes. The head node (index 0) originates a token for each event it has fully received. Every later node holds an arriving token until its own local "event complete" has been seen, and only then passes it on. The output of the last node is the token that the controller consumes. Each node keeps small pending counters so that tokens and local completions may arrive in either order. Sticky flags report counter underflow, triggers accepted while busy, and pending-counter overruns in the nodes.

Top module: `event_deadtime_ctrl`

## Requirements
- R1: After a synchronous active-high reset, occupancy_o is 0, busy_o is 0, receipt_o is 0, and underflow_o, overflow_o and every node_err_o bit are 0.
- R2: A cycle with trig_i high and receipt_o low raises occupancy_o by one at the next clock edge, but not past BUF_EVENTS.
- R3: A cycle with receipt_o high and trig_i low lowers occupancy_o by one at the next clock edge when it is non-zero.
- R4: A cycle with trig_i and receipt_o both high leaves occupancy_o unchanged.
- R5: busy_o is high exactly when occupancy_o is at least BUF_EVENTS-1 (7 with the default depth of 8).
- R6: trig_i high while busy_o is high sets overflow_o at the next edge. overflow_o then stays high until reset. A trigger at occupancy BUF_EVENTS leaves the count at BUF_EVENTS.
- R7: receipt_o high with trig_i low while occupancy_o is 0 sets underflow_o, which stays high until reset, and leaves occupancy_o at 0.
- R8: The head node (index 0) emits a pulse in the cycle after each of its local completions. Node k>0 emits a pulse in the cycle after the first cycle in which it has both an upstream pulse (pending or arriving) and a local completion (pending or arriving). It uses up one of each per pulse and emits at most one pulse per cycle.
- R9: Each node's pending counters hold at most 2^PEND_W-1 items. An arrival that finds its counter full and is not consumed in the same cycle is dropped and sets that node's node_err_o bit until reset.
- R10: receipt_o is the output pulse of the last node, node NUM_NODES-1. The occupancy counter acts on it at the same clock edge at which the bench sees it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | One pulse per accepted trigger |
| local_done_i | input | NUM_NODES | Per-node local event-complete pulse, bit 0 = head node |
| busy_o | output | 1 | Dead-time request |
| occupancy_o | output | CNT_W | Events still outstanding in the front-end buffer |
| receipt_o | output | 1 | Completion token leaving the last node |
| underflow_o | output | 1 | Sticky: token arrived with zero outstanding |
| overflow_o | output | 1 | Sticky: trigger arrived while busy |
| node_err_o | output | NUM_NODES | Sticky per-node pending-counter overrun |

## Verification
The bench builds the block with NUM_NODES=3, BUF_EVENTS=8 and PEND_W=2. Three nodes are enough to show a token waiting at a middle node while the tail node already holds completions, and out-of-order arrival in both directions. A pending limit of 3 lets four unmatched completions overrun a node within a few cycles. The default depth of 8 lets the bench fill the buffer to the busy threshold and beyond it, reaching saturation, the overflow flag and same-cycle trigger/token collisions near the full mark.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    typedef struct packed {
        logic underflow;
        logic overflow;
    } dtc_flags_t;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_UP   = 2'd1,
        CNT_DOWN = 2'd2
    } cnt_op_e;

    function automatic cnt_op_e pick_op(input logic add, input logic take);
        if (add && !take)      return CNT_UP;
        else if (take && !add) return CNT_DOWN;
        else                   return CNT_HOLD;
    endfunction

endpackage

// File: rtl/dtc_chain_node.sv
module dtc_chain_node
    import dtc_pkg::*;
#(
    parameter int IS_HEAD = 0,
    parameter int PEND_W  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic up_pulse_i,
    input  logic local_done_i,
    output logic down_pulse_o,
    output logic overrun_o
);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    logic [PEND_W-1:0] up_cnt, loc_cnt;
    logic up_avail, loc_avail, fire;
    cnt_op_e up_op, loc_op;

    generate
        if (IS_HEAD != 0) begin : g_head
            assign up_avail = 1'b1;
        end else begin : g_body
            assign up_avail = (up_cnt != '0) || up_pulse_i;
        end
    endgenerate

    assign loc_avail = (loc_cnt != '0) || local_done_i;
    assign fire      = up_avail && loc_avail;
    assign up_op     = pick_op(up_pulse_i, fire && (IS_HEAD == 0));
    assign loc_op    = pick_op(local_done_i, fire);

    always_ff @(posedge clk) begin
        if (rst) begin
            up_cnt       <= '0;
            loc_cnt      <= '0;
            down_pulse_o <= 1'b0;
            overrun_o    <= 1'b0;
        end else begin
            down_pulse_o <= fire;
            unique case (up_op)
                CNT_UP: begin
                    if (up_cnt == PEND_MAX) overrun_o <= 1'b1;
                    else                    up_cnt <= up_cnt + 1'b1;
                end
                CNT_DOWN: up_cnt <= up_cnt - 1'b1;
                default:  up_cnt <= up_cnt;
            endcase
            unique case (loc_op)
                CNT_UP: begin
                    if (loc_cnt == PEND_MAX) overrun_o <= 1'b1;
                    else                     loc_cnt <= loc_cnt + 1'b1;
                end
                CNT_DOWN: loc_cnt <= loc_cnt - 1'b1;
                default:  loc_cnt <= loc_cnt;
            endcase
        end
    end
endmodule

// File: rtl/dtc_occupancy.sv
module dtc_occupancy
    import dtc_pkg::*;
#(
    parameter int BUF_EVENTS = 8,
    parameter int CNT_W      = $clog2(BUF_EVENTS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_i,
    input  logic             receipt_i,
    output logic [CNT_W-1:0] count_o,
    output logic             busy_o,
    output dtc_flags_t       flags_o
);
    localparam logic [CNT_W-1:0] FULL_LEVEL = CNT_W'(BUF_EVENTS);
    localparam logic [CNT_W-1:0] BUSY_LEVEL = CNT_W'(BUF_EVENTS - 1);

    cnt_op_e op;
    assign op     = pick_op(trig_i, receipt_i);
    assign busy_o = (count_o >= BUSY_LEVEL);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
            flags_o <= '0;
        end else begin
            if (trig_i && busy_o) flags_o.overflow <= 1'b1;
            unique case (op)
                CNT_UP: begin
                    if (count_o != FULL_LEVEL) count_o <= count_o + 1'b1;
                end
                CNT_DOWN: begin
                    if (count_o == '0) flags_o.underflow <= 1'b1;
                    else               count_o <= count_o - 1'b1;
                end
                default: count_o <= count_o;
            endcase
        end
    end
endmodule

// File: rtl/event_deadtime_ctrl.sv
module event_deadtime_ctrl
    import dtc_pkg::*;
#(
    parameter int NUM_NODES  = 4,
    parameter int BUF_EVENTS = 8,
    parameter int PEND_W     = 3,
    parameter int CNT_W      = $clog2(BUF_EVENTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 trig_i,
    input  logic [NUM_NODES-1:0] local_done_i,
    output logic                 busy_o,
    output logic [CNT_W-1:0]     occupancy_o,
    output logic                 receipt_o,
    output logic                 underflow_o,
    output logic                 overflow_o,
    output logic [NUM_NODES-1:0] node_err_o
);
    logic [NUM_NODES:0] link;
    dtc_flags_t         flags;

    assign link[0] = 1'b0;

    generate
        for (genvar g = 0; g < NUM_NODES; g++) begin : g_node
            dtc_chain_node #(
                .IS_HEAD ((g == 0) ? 1 : 0),
                .PEND_W  (PEND_W)
            ) u_node (
                .clk          (clk),
                .rst          (rst),
                .up_pulse_i   (link[g]),
                .local_done_i (local_done_i[g]),
                .down_pulse_o (link[g+1]),
                .overrun_o    (node_err_o[g])
            );
        end
    endgenerate

    assign receipt_o = link[NUM_NODES];

    dtc_occupancy #(
        .BUF_EVENTS (BUF_EVENTS),
        .CNT_W      (CNT_W)
    ) u_occ (
        .clk       (clk),
        .rst       (rst),
        .trig_i    (trig_i),
        .receipt_i (receipt_o),
        .count_o   (occupancy_o),
        .busy_o    (busy_o),
        .flags_o   (flags)
    );

    assign underflow_o = flags.underflow;
    assign overflow_o  = flags.overflow;
endmodule

// File: rtl/dtc_checker.sv
module dtc_checker #(
    parameter int NUM_NODES  = 4,
    parameter int BUF_EVENTS = 8,
    parameter int CNT_W      = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 trig_i,
    input logic                 busy_o,
    input logic [CNT_W-1:0]     occupancy_o,
    input logic                 receipt_o,
    input logic                 underflow_o,
    input logic                 overflow_o,
    input logic [NUM_NODES-1:0] node_err_o
);
    localparam logic [CNT_W-1:0] FULL_LEVEL = CNT_W'(BUF_EVENTS);
    localparam logic [CNT_W-1:0] BUSY_LEVEL = CNT_W'(BUF_EVENTS - 1);

    AST_INCREMENT: assert property (@(posedge clk) disable iff (rst)
        (trig_i && !receipt_o && occupancy_o != FULL_LEVEL)
        |=> occupancy_o == $past(occupancy_o) + 1'b1); // R2

    AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (receipt_o && !trig_i && occupancy_o != '0)
        |=> occupancy_o == $past(occupancy_o) - 1'b1); // R3

    AST_COLLIDE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (trig_i && receipt_o) |=> $stable(occupancy_o)); // R4

    AST_BUSY_AT_THRESHOLD: assert property (@(posedge clk) disable iff (rst)
        (occupancy_o == BUSY_LEVEL - 1'b1 && trig_i && !receipt_o) |=> busy_o); // R5

    AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (rst)
        (trig_i && busy_o) |=> overflow_o); // R6

    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o); // R6

    AST_UNDERFLOW_SET: assert property (@(posedge clk) disable iff (rst)
        (receipt_o && !trig_i && occupancy_o == '0)
        |=> (underflow_o && occupancy_o == '0)); // R7

    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        underflow_o |=> underflow_o); // R7

    AST_NODE_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (node_err_o & $past(node_err_o)) == $past(node_err_o)); // R9

    AST_NEVER_ABOVE_FULL: assert property (@(posedge clk) disable iff (rst)
        occupancy_o <= FULL_LEVEL); // R6
endmodule

bind event_deadtime_ctrl dtc_checker #(
    .NUM_NODES  (NUM_NODES),
    .BUF_EVENTS (BUF_EVENTS),
    .CNT_W      (CNT_W)
) u_dtc_checker (
    .clk         (clk),
    .rst         (rst),
    .trig_i      (trig_i),
    .busy_o      (busy_o),
    .occupancy_o (occupancy_o),
    .receipt_o   (receipt_o),
    .underflow_o (underflow_o),
    .overflow_o  (overflow_o),
    .node_err_o  (node_err_o)
);

// File: tb/test_event_deadtime_ctrl.sv
module test_event_deadtime_ctrl;
    localparam int N     = 3;
    localparam int BUF   = 8;
    localparam int PW    = 2;
    localparam int CW    = $clog2(BUF + 1);
    localparam int PMAX  = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig_i = 1'b0;
    logic [N-1:0]  local_done_i = '0;
    logic          busy_o, receipt_o, underflow_o, overflow_o;
    logic [CW-1:0] occupancy_o;
    logic [N-1:0]  node_err_o;

    event_deadtime_ctrl #(.NUM_NODES(N), .BUF_EVENTS(BUF), .PEND_W(PW)) i_event_deadtime_ctrl (
        .clk(clk), .rst(rst), .trig_i(trig_i), .local_done_i(local_done_i),
        .busy_o(busy_o), .occupancy_o(occupancy_o), .receipt_o(receipt_o),
        .underflow_o(underflow_o), .overflow_o(overflow_o), .node_err_o(node_err_o)
    );

    always #5ns clk = ~clk;

    typedef struct {
        int       cnt;
        bit       busy;
        bit       rc;
        bit       uf;
        bit       of;
        bit [N-1:0] err;
        string    tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;

    int   mup[N];
    int   mloc[N];
    bit   mq[N];
    int   mcnt;
    bit   muf, mof;
    bit [N-1:0] merr;

    task automatic check(input string tag, input int act, input int expv, input string what);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            mup[i] = 0; mloc[i] = 0; mq[i] = 1'b0;
        end
        mcnt = 0; muf = 1'b0; mof = 1'b0; merr = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; trig_i = 1'b0; local_done_i = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    // Driver: applies one cycle of stimulus and pushes the expected post-edge state.
    task automatic step(input bit trig, input bit [N-1:0] done, input string tag);
        bit fire[N];
        bit rc, upin, upav, locav;
        exp_t e;
        @(negedge clk);
        trig_i = trig;
        local_done_i = done;
        rc = mq[N-1];
        for (int i = 0; i < N; i++) begin
            upin  = (i == 0) ? 1'b0 : mq[i-1];
            upav  = (i == 0) ? 1'b1 : (mup[i] != 0 || upin);
            locav = (mloc[i] != 0) || done[i];
            fire[i] = upav && locav;
            if (i != 0) begin
                if (upin && !fire[i]) begin
                    if (mup[i] == PMAX) merr[i] = 1'b1; else mup[i]++;
                end else if (fire[i] && !upin) mup[i]--;
            end
            if (done[i] && !fire[i]) begin
                if (mloc[i] == PMAX) merr[i] = 1'b1; else mloc[i]++;
            end else if (fire[i] && !done[i]) mloc[i]--;
        end
        if (trig && mcnt >= BUF - 1) mof = 1'b1;
        if (trig && !rc) begin
            if (mcnt < BUF) mcnt++;
        end else if (rc && !trig) begin
            if (mcnt == 0) muf = 1'b1; else mcnt--;
        end
        for (int i = 0; i < N; i++) mq[i] = fire[i];
        e.cnt = mcnt; e.busy = (mcnt >= BUF - 1); e.rc = mq[N-1];
        e.uf = muf; e.of = mof; e.err = merr; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: pops one expected item per cycle after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1ns;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, int'(occupancy_o), e.cnt, "occupancy");
                check(e.tag, int'(busy_o), int'(e.busy), "busy");
                check(e.tag, int'(receipt_o), int'(e.rc), "receipt");
                check(e.tag, int'(underflow_o), int'(e.uf), "underflow");
                check(e.tag, int'(overflow_o), int'(e.of), "overflow");
                check(e.tag, int'(node_err_o), int'(e.err), "node_err");
            end
        end
    end

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(1'b0, '0, tag);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #200us;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        model_clear();
        do_reset();
        #1ns;
        // R1: reset state
        check("R1", int'(occupancy_o), 0, "occupancy");
        check("R1", int'(busy_o), 0, "busy");
        check("R1", int'(receipt_o), 0, "receipt");
        check("R1", int'(underflow_o), 0, "underflow");
        check("R1", int'(overflow_o), 0, "overflow");
        check("R1", int'(node_err_o), 0, "node_err");

        // R2: triggers count up
        for (int k = 0; k < 3; k++) step(1'b1, '0, "R2");
        // R8: tail and middle finish before head; token passes once head finishes
        step(1'b0, 3'b100, "R8");
        step(1'b0, 3'b010, "R8");
        step(1'b0, 3'b001, "R8");
        idle(4, "R10");
        // R8: head first, token waits at middle node until it completes
        step(1'b0, 3'b001, "R8");
        idle(3, "R8");
        step(1'b0, 3'b010, "R8");
        idle(2, "R8");
        step(1'b0, 3'b100, "R3");
        idle(3, "R3");
        // R8: all three in one cycle, back-to-back events
        step(1'b0, 3'b111, "R8");
        step(1'b0, 3'b111, "R8");
        idle(4, "R7");
        // R7: extra event with zero outstanding -> underflow
        step(1'b0, 3'b111, "R7");
        idle(4, "R7");

        // R5/R6: fill past the threshold
        do_reset();
        for (int k = 0; k < 6; k++) step(1'b1, '0, "R2");
        step(1'b1, '0, "R5");
        idle(1, "R5");
        step(1'b1, '0, "R6");
        step(1'b1, '0, "R6");
        step(1'b1, '0, "R6");
        idle(2, "R6");
        // R4: token reaching controller while triggers keep arriving
        step(1'b0, 3'b111, "R4");
        step(1'b1, '0, "R4");
        step(1'b1, '0, "R4");
        step(1'b1, '0, "R4");
        step(1'b1, 3'b111, "R4");
        step(1'b1, '0, "R4");
        step(1'b1, '0, "R4");
        step(1'b1, '0, "R4");
        idle(2, "R5");
        // drain below threshold
        for (int k = 0; k < 3; k++) step(1'b0, 3'b111, "R3");
        idle(4, "R5");

        // R9: node overrun
        do_reset();
        for (int k = 0; k < 4; k++) step(1'b0, 3'b010, "R9");
        step(1'b0, 3'b010, "R9");
        idle(2, "R9");
        step(1'b0, 3'b001, "R9");
        idle(4, "R9");

        // R4: collision near zero
        do_reset();
        step(1'b1, '0, "R2");
        step(1'b0, 3'b111, "R4");
        step(1'b0, '0, "R4");
        step(1'b1, '0, "R4");
        idle(3, "R4");

        idle(2, "end");
        finish_run();
    end
endmodule